// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block holds the fetch address of a small 8-bit controller whose program memory is built from 16-bit words. Each cycle it picks one action and computes the next address from it. The actions are: advance by one, load an absolute target, call a subroutine, return from one, enter an interrupt, leave an interrupt, overwrite the low address byte, or add the accumulator to the low address byte. Return addresses go on a small hardware stack of fixed depth.

The program space is divided into pages. The high part of the counter selects the page and the low byte is the offset within it. A computed jump changes only the offset. A table that runs past the end of a page therefore wraps back to the start of the same page rather than spilling into the next one. A new page number can be written ahead of time. It is held back until the next write to, or add into, the low byte, so the fetch address never shows a half-updated value. Interrupt entry always goes to one fixed vector. Instruction decode, the program memory and interrupt arbitration sit outside this block.

Top module: `pcseq_top`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the fetch address is 000h, the stack is empty (empty=1, full=0), and the overflow flag, the underflow flag and the return-from-interrupt pulse are all 0.
- R2: An accepted step adds one to the 12-bit fetch address, wrapping from FFFh to 000h. With no control active, the address holds.
- R3: A jump loads the 12-bit target and discards any pending page value.
- R4: A call pushes the address after the current one and loads the target. A return pops the most recent entry into the fetch address, so nested calls come back in reverse order.
- R5: An interrupt entry pushes the current fetch address and loads 008h. A return from interrupt pops the stack, and the cycle in which the popped address appears is the only cycle in which the reti pulse is 1.
- R6: When no page value is pending, add-to-low loads the low 8 bits with (low byte + acc) mod 256 and leaves the upper 4 bits unchanged, even when the sum carries.
- R7: A page write alone does not change the fetch address. The value is held until the next low-byte write or add, which then uses it as the upper 4 bits. A page write in the same cycle as that operation is used at once.
- R8: The stack holds 8 entries, and full=1 when 8 are stored. A push onto a full stack overwrites the oldest entry and sets a sticky overflow flag that stays set until reset.
- R9: A pop from an empty stack loads 000h, leaves the stack empty, and sets a sticky underflow flag.
- R10: When controls collide, the priority is, from highest: reset, interrupt, call, jump, return, return from interrupt, low-byte write, add-to-low, step. Only the winning action takes effect.
- R11: A low-byte write loads the low 8 bits. The upper 4 bits come from the pending page value if there is one, and otherwise keep their current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on, pin or watchdog) |
| step_en | input | 1 | Advance fetch address by one |
| jmp_en | input | 1 | Load absolute target |
| call_en | input | 1 | Push return address and load target |
| tgt_addr | input | 12 | Target for jump and call |
| ret_en | input | 1 | Return from subroutine |
| irq_take | input | 1 | Enter interrupt at the fixed vector |
| reti_en | input | 1 | Return from interrupt |
| pcl_wr | input | 1 | Write the low address byte |
| pcl_wdata | input | 8 | Value for the low byte write |
| pch_wr | input | 1 | Stage a new page number |
| pch_wdata | input | 4 | Staged page number |
| pcl_add | input | 1 | Add accumulator to low byte |
| acc | input | 8 | Accumulator value |
| fetch_addr | output | 12 | Current fetch address |
| stk_full | output | 1 | Stack holds 8 entries |
| stk_empty | output | 1 | Stack holds no entries |
| stk_ovf | output | 1 | Sticky push-on-full flag |
| stk_unf | output | 1 | Sticky pop-on-empty flag |
| reti_pulse | output | 1 | One-cycle pulse after return from interrupt |

## Verification
The add-to-low path is swept over all 256 accumulator values from an offset near the end of a page. This separates a correct in-page wrap from a design that carries into the page number. Jumps are swept across the whole address range, and stepping is checked through the FFFh to 000h wrap. A chain of ten nested calls followed by nine returns shows both the reverse order of the returns and the loss of the two oldest entries on overflow, and it ends in an underflow. Stacked control combinations then show which action wins each collision and that the losing action leaves the stack untouched.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

   typedef enum logic [3:0] {
      ACT_HOLD,
      ACT_STEP,
      ACT_ADD,
      ACT_PCLW,
      ACT_RETI,
      ACT_RET,
      ACT_JMP,
      ACT_CALL,
      ACT_IRQ
   } pc_act_e;

endpackage

// File: rtl/pcseq_arb.sv
module pcseq_arb
   import pcseq_pkg::*;
(
   input  logic    irq_take,
   input  logic    call_en,
   input  logic    jmp_en,
   input  logic    ret_en,
   input  logic    reti_en,
   input  logic    pcl_wr,
   input  logic    pcl_add,
   input  logic    step_en,
   output pc_act_e act
);

   always_comb begin
      if (irq_take)     act = ACT_IRQ;
      else if (call_en) act = ACT_CALL;
      else if (jmp_en)  act = ACT_JMP;
      else if (ret_en)  act = ACT_RET;
      else if (reti_en) act = ACT_RETI;
      else if (pcl_wr)  act = ACT_PCLW;
      else if (pcl_add) act = ACT_ADD;
      else if (step_en) act = ACT_STEP;
      else              act = ACT_HOLD;
   end

endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
   parameter int W     = 12,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] push_data,
   output logic [W-1:0] top_data,
   output logic         full,
   output logic         empty,
   output logic         ovf,
   output logic         unf
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("pcseq_stack: DEPTH must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("pcseq_stack: W must be positive");
   end

   logic [PTR_W-1:0]          head_q;
   logic [PTR_W-1:0]          peek_idx;
   logic [PTR_W-1:0]          head_inc;
   logic [CNT_W-1:0]          cnt_q;
   logic [DEPTH-1:0][W-1:0]   lvl;

   assign peek_idx = (head_q == '0) ? PTR_W'(DEPTH - 1) : head_q - 1'b1;
   assign head_inc = (head_q == PTR_W'(DEPTH - 1)) ? '0 : head_q + 1'b1;
   assign full     = (cnt_q == CNT_W'(DEPTH));
   assign empty    = (cnt_q == '0);
   assign top_data = lvl[peek_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         cnt_q  <= '0;
         ovf    <= 1'b0;
         unf    <= 1'b0;
      end else if (push) begin
         head_q <= head_inc;
         if (full) ovf   <= 1'b1;
         else      cnt_q <= cnt_q + 1'b1;
      end else if (pop) begin
         if (empty) begin
            unf <= 1'b1;
         end else begin
            head_q <= peek_idx;
            cnt_q  <= cnt_q - 1'b1;
         end
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
      logic [W-1:0] ent_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            ent_q <= '0;
         else if (push && head_q == PTR_W'(i))  ent_q <= push_data;
      end
      assign lvl[i] = ent_q;
   end

   assert_ovf_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full) |=> (ovf && full));
   assert_unf_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty) |=> (unf && empty));
   assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);
   assert_flags_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({full, empty}));
   assert_no_push_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && pop));

endmodule

// File: rtl/pcseq_next.sv
module pcseq_next
   import pcseq_pkg::*;
#(
   parameter int PC_W    = 12,
   parameter int PAGE_W  = 8,
   parameter int IRQ_VEC = 8
) (
   input  pc_act_e                 act,
   input  logic [PC_W-1:0]         pc,
   input  logic [PC_W-1:0]         tgt,
   input  logic [PC_W-1:0]         stk_top,
   input  logic                    stk_empty,
   input  logic [PAGE_W-1:0]       pcl_wdata,
   input  logic [PAGE_W-1:0]       acc,
   input  logic [PC_W-PAGE_W-1:0]  pch_eff,
   output logic [PC_W-1:0]         nxt,
   output logic                    push,
   output logic [PC_W-1:0]         push_data,
   output logic                    pop
);

   localparam logic [PC_W-1:0] IRQ_V = PC_W'(IRQ_VEC);

   logic [PAGE_W-1:0] low_sum;
   assign low_sum = pc[PAGE_W-1:0] + acc;

   always_comb begin
      nxt       = pc;
      push      = 1'b0;
      push_data = pc;
      pop       = 1'b0;
      unique case (act)
         ACT_IRQ: begin
            push      = 1'b1;
            push_data = pc;
            nxt       = IRQ_V;
         end
         ACT_CALL: begin
            push      = 1'b1;
            push_data = pc + PC_W'(1);
            nxt       = tgt;
         end
         ACT_JMP:            nxt = tgt;
         ACT_RET, ACT_RETI: begin
            pop = 1'b1;
            nxt = stk_empty ? '0 : stk_top;
         end
         ACT_PCLW:           nxt = {pch_eff, pcl_wdata};
         ACT_ADD:            nxt = {pch_eff, low_sum};
         ACT_STEP:           nxt = pc + PC_W'(1);
         default:            nxt = pc;
      endcase
   end

endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
   import pcseq_pkg::*;
#(
   parameter int PC_W      = 12,
   parameter int PAGE_W    = 8,
   parameter int STK_DEPTH = 8,
   parameter int IRQ_VEC   = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   step_en,
   input  logic                   jmp_en,
   input  logic                   call_en,
   input  logic [PC_W-1:0]        tgt_addr,
   input  logic                   ret_en,
   input  logic                   irq_take,
   input  logic                   reti_en,
   input  logic                   pcl_wr,
   input  logic [PAGE_W-1:0]      pcl_wdata,
   input  logic                   pch_wr,
   input  logic [PC_W-PAGE_W-1:0] pch_wdata,
   input  logic                   pcl_add,
   input  logic [PAGE_W-1:0]      acc,
   output logic [PC_W-1:0]        fetch_addr,
   output logic                   stk_full,
   output logic                   stk_empty,
   output logic                   stk_ovf,
   output logic                   stk_unf,
   output logic                   reti_pulse
);

   localparam int PCH_W = PC_W - PAGE_W;

   if (PCH_W < 1) begin : g_bad_split
      $error("pcseq_top: PC_W must exceed PAGE_W");
   end
   if (IRQ_VEC < 0 || IRQ_VEC >= (1 << PC_W)) begin : g_bad_vec
      $error("pcseq_top: IRQ_VEC outside address space");
   end

   pc_act_e            act;
   logic [PC_W-1:0]    pc_q, pc_nxt, stk_top, push_data;
   logic               push, pop;
   logic [PCH_W-1:0]   pend_q, pch_eff;
   logic               pend_v_q;
   logic               consume, discard;

   pcseq_arb u_arb (
      .irq_take (irq_take),
      .call_en  (call_en),
      .jmp_en   (jmp_en),
      .ret_en   (ret_en),
      .reti_en  (reti_en),
      .pcl_wr   (pcl_wr),
      .pcl_add  (pcl_add),
      .step_en  (step_en),
      .act      (act)
   );

   assign pch_eff = pch_wr   ? pch_wdata :
                    pend_v_q ? pend_q    : pc_q[PC_W-1:PAGE_W];
   assign consume = (act == ACT_PCLW) || (act == ACT_ADD);
   assign discard = (act == ACT_JMP)  || (act == ACT_CALL);

   pcseq_next #(
      .PC_W    (PC_W),
      .PAGE_W  (PAGE_W),
      .IRQ_VEC (IRQ_VEC)
   ) u_next (
      .act       (act),
      .pc        (pc_q),
      .tgt       (tgt_addr),
      .stk_top   (stk_top),
      .stk_empty (stk_empty),
      .pcl_wdata (pcl_wdata),
      .acc       (acc),
      .pch_eff   (pch_eff),
      .nxt       (pc_nxt),
      .push      (push),
      .push_data (push_data),
      .pop       (pop)
   );

   pcseq_stack #(
      .W     (PC_W),
      .DEPTH (STK_DEPTH)
   ) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .pop       (pop),
      .push_data (push_data),
      .top_data  (stk_top),
      .full      (stk_full),
      .empty     (stk_empty),
      .ovf       (stk_ovf),
      .unf       (stk_unf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q       <= '0;
         pend_q     <= '0;
         pend_v_q   <= 1'b0;
         reti_pulse <= 1'b0;
      end else begin
         pc_q       <= pc_nxt;
         reti_pulse <= (act == ACT_RETI);
         if (consume || discard) begin
            pend_v_q <= 1'b0;
         end else if (pch_wr) begin
            pend_q   <= pch_wdata;
            pend_v_q <= 1'b1;
         end
      end
   end

   assign fetch_addr = pc_q;

   assert_irq_vec_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_IRQ) |=> (fetch_addr == PC_W'(IRQ_VEC)));
   assert_reti_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_RETI) |=> reti_pulse);
   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_STEP) |=> (fetch_addr == $past(fetch_addr) + PC_W'(1)));
   assert_page_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_ADD && !pch_wr && !pend_v_q)
      |=> (fetch_addr[PC_W-1:PAGE_W] == $past(fetch_addr[PC_W-1:PAGE_W])));
   assert_stage_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_HOLD) |=> $stable(fetch_addr));
   assert_jmp_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_JMP) |=> (fetch_addr == $past(tgt_addr)));

endmodule

// File: tb/pcseq_top_tb.sv
module pcseq_top_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step_en = 0, jmp_en = 0, call_en = 0, ret_en = 0;
   logic        irq_take = 0, reti_en = 0, pcl_wr = 0, pch_wr = 0, pcl_add = 0;
   logic [11:0] tgt_addr = '0;
   logic [7:0]  pcl_wdata = '0, acc = '0;
   logic [3:0]  pch_wdata = '0;
   logic [11:0] fetch_addr;
   logic        stk_full, stk_empty, stk_ovf, stk_unf, reti_pulse;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   pcseq_top u_dut (
      .clk(clk), .rst_n(rst_n), .step_en(step_en), .jmp_en(jmp_en),
      .call_en(call_en), .tgt_addr(tgt_addr), .ret_en(ret_en),
      .irq_take(irq_take), .reti_en(reti_en), .pcl_wr(pcl_wr),
      .pcl_wdata(pcl_wdata), .pch_wr(pch_wr), .pch_wdata(pch_wdata),
      .pcl_add(pcl_add), .acc(acc), .fetch_addr(fetch_addr),
      .stk_full(stk_full), .stk_empty(stk_empty), .stk_ovf(stk_ovf),
      .stk_unf(stk_unf), .reti_pulse(reti_pulse)
   );

   task automatic chk(input string req, input int actual, input int expected);
      checks++;
      if (actual !== expected) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
      end
   endtask

   task automatic idle_all();
      step_en = 0; jmp_en = 0; call_en = 0; ret_en = 0; irq_take = 0;
      reti_en = 0; pcl_wr = 0; pch_wr = 0; pcl_add = 0;
   endtask

   task automatic nxt();
      @(negedge clk);
      idle_all();
   endtask

   task automatic do_jmp(input int a);
      jmp_en = 1; tgt_addr = 12'(a); nxt();
   endtask

   task automatic do_call(input int a);
      call_en = 1; tgt_addr = 12'(a); nxt();
   endtask

   task automatic do_ret();
      ret_en = 1; nxt();
   endtask

   task automatic check_reset(input string req);
      chk(req, fetch_addr, 0);
      chk(req, stk_empty, 1);
      chk(req, stk_full, 0);
      chk(req, stk_ovf, 0);
      chk(req, stk_unf, 0);
      chk(req, reti_pulse, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int ra [10];
      int p;
      @(negedge clk);
      @(negedge clk);
      check_reset("R1 in reset");
      rst_n = 1;
      @(negedge clk);
      check_reset("R1 after reset");

      // R2 step and hold
      for (int i = 1; i <= 20; i++) begin
         step_en = 1; nxt();
         chk("R2 step", fetch_addr, i);
      end
      do_jmp(12'hFFE);
      step_en = 1; nxt();
      chk("R2 step FFF", fetch_addr, 12'hFFF);
      step_en = 1; nxt();
      chk("R2 wrap", fetch_addr, 0);
      nxt(); nxt();
      chk("R2 hold", fetch_addr, 0);

      // R3 jump sweep
      for (int a = 0; a < 4096; a += 37) begin
         do_jmp(a);
         chk("R3 jump", fetch_addr, a);
      end
      do_jmp(12'h123);
      pch_wr = 1; pch_wdata = 4'h5; nxt();
      do_jmp(12'h123);
      pcl_wr = 1; pcl_wdata = 8'h44; nxt();
      chk("R3 pending discarded", fetch_addr, 12'h144);

      // R6 add-to-low sweep over all acc values
      for (int v = 0; v < 256; v++) begin
         do_jmp(12'h3F0);
         pcl_add = 1; acc = 8'(v); nxt();
         chk("R6 add in page", fetch_addr, 12'h300 | ((8'hF0 + v) & 8'hFF));
      end

      // R7 / R11 page staging
      do_jmp(12'h2A5);
      pch_wr = 1; pch_wdata = 4'h7; nxt();
      chk("R7 staged no change", fetch_addr, 12'h2A5);
      step_en = 1; nxt();
      chk("R7 step keeps page", fetch_addr, 12'h2A6);
      pcl_wr = 1; pcl_wdata = 8'h10; nxt();
      chk("R7 staged applied", fetch_addr, 12'h710);
      pcl_wr = 1; pcl_wdata = 8'h20; nxt();
      chk("R11 low write keeps page", fetch_addr, 12'h720);
      pch_wr = 1; pch_wdata = 4'h9; pcl_wr = 1; pcl_wdata = 8'h33; nxt();
      chk("R7 same cycle", fetch_addr, 12'h933);
      pch_wr = 1; pch_wdata = 4'h2; nxt();
      pcl_add = 1; acc = 8'h10; nxt();
      chk("R7 staged with add", fetch_addr, 12'h243);

      // R4 nested call/return
      do_jmp(12'h100);
      do_call(12'h500);
      chk("R4 call target", fetch_addr, 12'h500);
      chk("R4 not empty", stk_empty, 0);
      do_call(12'h600);
      do_ret();
      chk("R4 inner return", fetch_addr, 12'h501);
      do_ret();
      chk("R4 outer return", fetch_addr, 12'h101);
      chk("R4 empty", stk_empty, 1);

      // R5 interrupt
      do_jmp(12'h234);
      irq_take = 1; nxt();
      chk("R5 vector", fetch_addr, 12'h008);
      step_en = 1; nxt();
      reti_en = 1; nxt();
      chk("R5 reti addr", fetch_addr, 12'h234);
      chk("R5 reti pulse", reti_pulse, 1);
      nxt();
      chk("R5 pulse ends", reti_pulse, 0);

      // R8 overflow then R9 underflow
      do_jmp(12'h040);
      p = 12'h040;
      for (int k = 0; k < 10; k++) begin
         ra[k] = p + 1;
         p = 12'h100 + k * 16;
         do_call(p);
         if (k == 7) begin
            chk("R8 full at 8", stk_full, 1);
            chk("R8 no ovf yet", stk_ovf, 0);
         end
      end
      chk("R8 ovf set", stk_ovf, 1);
      chk("R8 still full", stk_full, 1);
      for (int k = 9; k >= 2; k--) begin
         do_ret();
         chk("R8 lifo after overwrite", fetch_addr, ra[k]);
      end
      chk("R8 empty after 8", stk_empty, 1);
      chk("R9 no unf yet", stk_unf, 0);
      do_jmp(12'h777);
      do_ret();
      chk("R9 underflow addr", fetch_addr, 0);
      chk("R9 unf set", stk_unf, 1);
      chk("R9 still empty", stk_empty, 1);
      chk("R8 ovf sticky", stk_ovf, 1);
      rst_n = 0;
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check_reset("R1 second reset");

      // R10 priority
      do_jmp(12'h3C0);
      irq_take = 1; call_en = 1; jmp_en = 1; tgt_addr = 12'h700;
      step_en = 1; ret_en = 1; nxt();
      chk("R10 irq wins", fetch_addr, 12'h008);
      chk("R10 one push", stk_empty, 0);
      reti_en = 1; nxt();
      chk("R10 irq pushed pc", fetch_addr, 12'h3C0);
      chk("R10 stack back empty", stk_empty, 1);
      call_en = 1; jmp_en = 1; ret_en = 1; tgt_addr = 12'h700; nxt();
      chk("R10 call over jmp/ret", fetch_addr, 12'h700);
      do_ret();
      chk("R10 call pushed", fetch_addr, 12'h3C1);
      jmp_en = 1; tgt_addr = 12'h812; ret_en = 1; step_en = 1; nxt();
      chk("R10 jmp over ret", fetch_addr, 12'h812);
      chk("R10 ret ignored unf", stk_unf, 0);
      do_call(12'h555);
      ret_en = 1; reti_en = 1; nxt();
      chk("R10 ret over reti", fetch_addr, 12'h813);
      chk("R10 no reti pulse", reti_pulse, 0);
      pcl_wr = 1; pcl_wdata = 8'h20; pcl_add = 1; acc = 8'h05; step_en = 1; nxt();
      chk("R10 low write over add", fetch_addr, 12'h820);
      pcl_add = 1; acc = 8'h05; step_en = 1; nxt();
      chk("R10 add over step", fetch_addr, 12'h825);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule